// File: doc/BRIEF.md
# Two-Level Edge-Capture Interrupt Aggregator

This block collects eight event sources of a mixed-signal controller into one interrupt line. Five of them form a converter group: a conversion-complete strobe and four digital comparator hits. The other three form a clock group: a periodic event, a one-second tick and an alarm. Each source has a sticky status bit that is set by a rising edge on the source. Each source also has a mask bit. The unmasked status bits of a group combine into one first-level interrupt for that group. The two first-level interrupts are then ORed into the single output `irq`.

Software finds the cause of an interrupt by reading a group's status register, and that read clears the bits it returned. Software can mask sources one by one. A masked source still records its events, so software can poll it. The sources are single-bit inputs that are synchronous to `clk`. The register port is a plain strobe interface: a write takes effect at the clock edge that samples it, and read data appears on `reg_rdata` one cycle after the read strobe.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, all status bits and all mask bits are 0, and `irq`, `conv_irq` and `clock_irq` are low.
- R2: A status bit is set at the clock edge that first sees its source high after a cycle with the source low. A source that stays high does not set the bit again after it has been cleared.
- R3: A read of status address 0x1A returns the converter group in the cycle after the strobe. Conversion-complete is at bit 8, and comparators 4, 3, 2 and 1 are at bits 7, 6, 5 and 4. A read of status address 0x19 returns the clock group: periodic at bit 7, one-second at bit 6, alarm at bit 5. The read clears that group's status bits. `reg_rdata` is 0 in any cycle that does not follow a read strobe.
- R4: If a rising edge arrives in the same cycle as a read of its status register, the read returns the old value and the bit stays set afterwards.
- R5: A mask bit of 1 keeps its status bit out of the group's first-level interrupt, and 0 lets it through. A masked source still sets its status bit.
- R6: `conv_irq` is high while any unmasked converter status bit is set. `clock_irq` is high while any unmasked clock status bit is set. `irq` is the OR of the two.
- R7: The converter masks are written and read at address 0x22, and the clock masks at address 0x21, in the same bit positions as their status bits. Reading a mask register changes nothing.
- R8: Unused bit positions read as 0 and ignore writes. Writes to status addresses have no effect. A read of any other address returns 0 and clears nothing.
- R9: Clearing the mask bit of a status bit that is already set raises the group interrupt in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_done | input | 1 | Converter conversion-complete source |
| cmp_hit | input | 4 | Comparator sources, bit 0 is comparator 1 |
| rtc_periodic | input | 1 | Clock periodic source |
| rtc_second | input | 1 | Clock one-second tick source |
| rtc_alarm | input | 1 | Clock alarm source |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data, valid the cycle after `reg_rd` |
| conv_irq | output | 1 | First-level converter group interrupt |
| clock_irq | output | 1 | First-level clock group interrupt |
| irq | output | 1 | Combined interrupt output |

## Verification
A wrong status or mask bit shows up on the group interrupt in the cycle after the edge or write that caused it. It also shows up on `reg_rdata` one cycle after the next read strobe of that group. Because reads clear the status, the bench reads each group twice in a row. A bit that was wrongly kept shows up on the second read, and a bit that was wrongly dropped shows up on the first read and on the missing interrupt. The same-cycle race between a new edge and a read is driven on purpose to check that no event is lost.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

   localparam int unsigned REG_AW = 8;
   localparam int unsigned REG_DW = 16;

   // converter group: conversion-complete plus four comparators
   localparam int unsigned        CONV_SRC_N = 5;
   localparam int unsigned        CONV_LSB   = 4;
   localparam logic [REG_AW-1:0]  CONV_STAT  = 8'h1A;
   localparam logic [REG_AW-1:0]  CONV_MASK  = 8'h22;

   // clock group: alarm, one-second, periodic
   localparam int unsigned        CLK_SRC_N  = 3;
   localparam int unsigned        CLK_LSB    = 5;
   localparam logic [REG_AW-1:0]  CLK_STAT   = 8'h19;
   localparam logic [REG_AW-1:0]  CLK_MASK   = 8'h21;

   typedef struct packed {
      logic              wr;
      logic              rd;
      logic [REG_AW-1:0] addr;
      logic [REG_DW-1:0] wdata;
   } reg_req_t;

endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
   parameter int unsigned N         = 1,
   parameter bit          PREV_INIT = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] src,
   output logic [N-1:0] rise
);

   if (N < 1) begin : g_bad_n
      $error("irq_edge_detect: N must be at least 1");
   end

   logic [N-1:0] prev_q;

   for (genvar i = 0; i < N; i++) begin : g_bit
      if (PREV_INIT) begin : g_arm_high
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q[i] <= 1'b1;
            else        prev_q[i] <= src[i];
         end
      end else begin : g_arm_low
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q[i] <= 1'b0;
            else        prev_q[i] <= src[i];
         end
      end
      assign rise[i] = src[i] & ~prev_q[i];
   end

endmodule

// File: rtl/irq_src_group.sv
module irq_src_group
   import irq_agg_pkg::*;
#(
   parameter int unsigned      N         = 1,
   parameter int unsigned      LSB       = 0,
   parameter logic [REG_AW-1:0] STAT_ADDR = '0,
   parameter logic [REG_AW-1:0] MASK_ADDR = 8'h01
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N-1:0]      src,
   input  reg_req_t          req,
   output logic [REG_DW-1:0] rdata,
   output logic              lvl_irq
);

   localparam int unsigned MSB = LSB + N - 1;

   if (MSB >= REG_DW) begin : g_bad_span
      $error("irq_src_group: field exceeds data width");
   end
   if (STAT_ADDR == MASK_ADDR) begin : g_bad_addr
      $error("irq_src_group: status and mask share an address");
   end

   logic [N-1:0] rise;
   logic [N-1:0] stat_q, stat_d;
   logic [N-1:0] mask_q, mask_d;
   logic         stat_rd;
   logic         mask_wr;

   irq_edge_detect #(
      .N         (N),
      .PREV_INIT (1'b0)
   ) i_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .src   (src),
      .rise  (rise)
   );

   assign stat_rd = req.rd && (req.addr == STAT_ADDR);
   assign mask_wr = req.wr && (req.addr == MASK_ADDR);

   always_comb begin
      stat_d = (stat_rd ? '0 : stat_q) | rise;
      mask_d = mask_wr ? req.wdata[LSB +: N] : mask_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= '0;
         mask_q <= '0;
      end else begin
         stat_q <= stat_d;
         mask_q <= mask_d;
      end
   end

   always_comb begin
      rdata = '0;
      if (req.addr == STAT_ADDR)      rdata[LSB +: N] = stat_q;
      else if (req.addr == MASK_ADDR) rdata[LSB +: N] = mask_q;
   end

   assign lvl_irq = |(stat_q & ~mask_q);

   // R2
   stat_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|rise) |=> ((stat_q & $past(rise)) == $past(rise)));

   // R2
   stat_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|stat_q) |-> ((stat_q & ~$past(stat_q) & ~$past(rise)) == '0));

   // R3
   stat_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && (rise == '0)) |=> (stat_q == '0));

   // R4
   stat_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && (rise != '0)) |=> ((stat_q & $past(rise)) != '0));

   // R7
   mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mask_wr |=> $stable(mask_q));

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
   import irq_agg_pkg::*;
#(
   parameter int unsigned ADDR_W = REG_AW,
   parameter int unsigned DATA_W = REG_DW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              conv_done,
   input  logic [3:0]        cmp_hit,
   input  logic              rtc_periodic,
   input  logic              rtc_second,
   input  logic              rtc_alarm,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              conv_irq,
   output logic              clock_irq,
   output logic              irq
);

   if (ADDR_W != REG_AW || DATA_W != REG_DW) begin : g_bad_bus
      $error("irq_aggregator: bus widths must match the package");
   end

   reg_req_t          req;
   logic [REG_DW-1:0] conv_rdata, clk_rdata;
   logic [REG_DW-1:0] rdata_q;

   assign req.wr    = reg_wr;
   assign req.rd    = reg_rd;
   assign req.addr  = reg_addr;
   assign req.wdata = reg_wdata;

   irq_src_group #(
      .N         (CONV_SRC_N),
      .LSB       (CONV_LSB),
      .STAT_ADDR (CONV_STAT),
      .MASK_ADDR (CONV_MASK)
   ) i_conv_grp (
      .clk     (clk),
      .rst_n   (rst_n),
      .src     ({conv_done, cmp_hit}),
      .req     (req),
      .rdata   (conv_rdata),
      .lvl_irq (conv_irq)
   );

   irq_src_group #(
      .N         (CLK_SRC_N),
      .LSB       (CLK_LSB),
      .STAT_ADDR (CLK_STAT),
      .MASK_ADDR (CLK_MASK)
   ) i_clk_grp (
      .clk     (clk),
      .rst_n   (rst_n),
      .src     ({rtc_periodic, rtc_second, rtc_alarm}),
      .req     (req),
      .rdata   (clk_rdata),
      .lvl_irq (clock_irq)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rdata_q <= '0;
      else if (reg_rd) rdata_q <= conv_rdata | clk_rdata;
      else             rdata_q <= '0;
   end

   assign reg_rdata = rdata_q;
   assign irq       = conv_irq | clock_irq;

   // R3
   rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rd |=> (reg_rdata == '0));

   // R8
   rdata_unused_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata[15:9] == '0) && (reg_rdata[3:0] == '0));

endmodule

// File: tb/test_irq_aggregator.sv
module test_irq_aggregator;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        conv_done = 1'b0;
   logic [3:0]  cmp_hit = '0;
   logic        rtc_periodic = 1'b0;
   logic        rtc_second = 1'b0;
   logic        rtc_alarm = 1'b0;
   logic        reg_wr = 1'b0;
   logic        reg_rd = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        conv_irq, clock_irq, irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct {
      logic [15:0] exp;
      string       tag;
   } sb_item_t;

   sb_item_t sb_q[$];
   sb_item_t item;
   logic     rd_d = 1'b0;

   always #2 clk = ~clk;

   irq_aggregator i_irq_aggregator (
      .clk          (clk),
      .rst_n        (rst_n),
      .conv_done    (conv_done),
      .cmp_hit      (cmp_hit),
      .rtc_periodic (rtc_periodic),
      .rtc_second   (rtc_second),
      .rtc_alarm    (rtc_alarm),
      .reg_wr       (reg_wr),
      .reg_rd       (reg_rd),
      .reg_addr     (reg_addr),
      .reg_wdata    (reg_wdata),
      .reg_rdata    (reg_rdata),
      .conv_irq     (conv_irq),
      .clock_irq    (clock_irq),
      .irq          (irq)
   );

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   always @(posedge clk) rd_d <= reg_rd;

   // monitor: read data is registered, so it is valid at the negedge after the strobe edge
   always @(negedge clk) begin
      if (rd_d) begin
         if (sb_q.size() == 0) begin
            chk("R3 scoreboard underflow", 16'h1, 16'h0);
         end else begin
            item = sb_q.pop_front();
            chk(item.tag, reg_rdata, item.exp);
         end
      end else if (rst_n) begin
         chk("R3 idle rdata", reg_rdata, 16'h0);
      end
   end

   task automatic do_read(input logic [7:0] addr, input logic [15:0] exp, input string tag);
      @(negedge clk);
      reg_rd   = 1'b1;
      reg_addr = addr;
      sb_q.push_back('{exp: exp, tag: tag});
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic do_write(input logic [7:0] addr, input logic [15:0] data);
      @(negedge clk);
      reg_wr    = 1'b1;
      reg_addr  = addr;
      reg_wdata = data;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   // one-cycle pulses; returns at the negedge after the capturing edge
   task automatic pulse(input logic [4:0] conv, input logic [2:0] clks);
      @(negedge clk);
      {conv_done, cmp_hit}                   = conv;
      {rtc_periodic, rtc_second, rtc_alarm} = clks;
      @(negedge clk);
      {conv_done, cmp_hit}                   = '0;
      {rtc_periodic, rtc_second, rtc_alarm} = '0;
   endtask

   function automatic logic [15:0] irqs();
      return {13'd0, irq, conv_irq, clock_irq};
   endfunction

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual %0d expected %0d", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 irq lines", irqs(), 16'h0);
      do_read(8'h1A, 16'h0000, "R1 conv status");
      do_read(8'h22, 16'h0000, "R1 conv mask");
      do_read(8'h19, 16'h0000, "R1 clock status");
      do_read(8'h21, 16'h0000, "R1 clock mask");

      // R2 R6 conversion-complete
      pulse(5'b10000, 3'b000);
      chk("R6 conv only", irqs(), 16'h6);
      do_read(8'h1A, 16'h0100, "R3 conv-done bit 8");
      chk("R6 cleared by read", irqs(), 16'h0);
      do_read(8'h1A, 16'h0000, "R3 read clears");

      // R3 comparator positions
      pulse(5'b00101, 3'b000);
      do_read(8'h1A, 16'h0050, "R3 cmp1 cmp3");

      // R5 R7 R8 masks
      do_write(8'h22, 16'hFFFF);
      do_read(8'h22, 16'h01F0, "R8 mask unused bits");
      do_read(8'h22, 16'h01F0, "R7 mask read no side effect");
      pulse(5'b01000, 3'b000);
      chk("R5 masked blocks irq", irqs(), 16'h0);
      do_write(8'h22, 16'h0000);
      chk("R9 unmask raises irq", irqs(), 16'h6);
      do_read(8'h1A, 16'h0080, "R5 masked still latched cmp4");

      // R8 status writes ignored
      pulse(5'b00000, 3'b001);
      chk("R6 clock only", irqs(), 16'h5);
      do_write(8'h19, 16'hFFFF);
      do_write(8'h19, 16'h0000);
      do_read(8'h19, 16'h0020, "R8 status write ignored");

      // R5 partial mask on clock group
      do_write(8'h21, 16'h0040);
      pulse(5'b00000, 3'b110);
      chk("R5 periodic unmasked", irqs(), 16'h5);
      do_read(8'h19, 16'h00C0, "R3 periodic and second");
      do_read(8'h21, 16'h0040, "R7 clock mask");
      pulse(5'b00000, 3'b010);
      chk("R5 second masked", irqs(), 16'h0);
      do_read(8'h19, 16'h0040, "R5 second latched");
      do_write(8'h21, 16'h0000);

      // R4 edge in the same cycle as the read
      pulse(5'b00000, 3'b010);
      @(negedge clk);
      reg_rd    = 1'b1;
      reg_addr  = 8'h19;
      rtc_alarm = 1'b1;
      sb_q.push_back('{exp: 16'h0040, tag: "R4 read returns old"});
      @(negedge clk);
      reg_rd    = 1'b0;
      rtc_alarm = 1'b0;
      chk("R4 irq kept", irqs(), 16'h5);
      do_read(8'h19, 16'h0020, "R4 alarm survives read");
      do_read(8'h19, 16'h0000, "R4 then cleared");

      // R2 held level
      @(negedge clk);
      rtc_periodic = 1'b1;
      do_read(8'h19, 16'h0080, "R2 level first edge");
      do_read(8'h19, 16'h0000, "R2 held level no reset");
      chk("R2 held level irq", irqs(), 16'h0);
      @(negedge clk);
      rtc_periodic = 1'b0;

      // R8 unknown address
      pulse(5'b10000, 3'b000);
      do_read(8'h20, 16'h0000, "R8 unknown address");
      do_read(8'h1A, 16'h0100, "R8 unknown read kept status");

      // R6 combined output
      pulse(5'b10000, 3'b001);
      chk("R6 both groups", irqs(), 16'h7);
      do_read(8'h1A, 16'h0100, "R6 conv part");
      chk("R6 clock still", irqs(), 16'h5);
      do_read(8'h19, 16'h0020, "R6 clock part");
      chk("R6 all clear", irqs(), 16'h0);

      repeat (3) @(negedge clk);
      chk("R3 scoreboard drained", 16'(sb_q.size()), 16'h0);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule